// File: doc/BRIEF.md
# Register-Programmed PWM Timer

This block is a single-channel pulse-width modulation timer that software programs through four registers: a running counter, a period length, a duty length and a control word. While it runs, the counter advances once per timer tick and folds back to zero at the end of each period. The output is driven from a comparison of the counter against the duty and period values. A build-time parameter picks one of three register layouts. The layouts differ in where each register sits, in how the control bits are read, and in whether the timer tick is the input clock or the input clock divided by two.

The bus side is a plain strobe interface. A write strobe stores data at the decoded register in the same edge. A read strobe captures the addressed register into a read-data register at that edge. After changing period and duty, software normally writes zero to the counter to start a fresh cycle. The output pin is registered, so it never glitches while the comparison settles.

Top module: `pwm_regtimer`

## Requirements
- R1: With LAYOUT=0 the register slot is taken from address bits [3:2]: slot 0 is the counter, slot 1 the duty, slot 2 the period and slot 3 the control word. Address bits [1:0] are ignored.
- R2: With LAYOUT=1 slot 0 is the counter, slot 1 the period, slot 2 the duty and slot 3 the control word.
- R3: With LAYOUT=2 slot 0 is the control word, slot 1 the period, slot 2 the duty and slot 3 the counter.
- R4: A read strobe loads bus_rdata at that clock edge with the addressed register's value from before the edge. bus_rdata holds its value while no read is strobed. The control word keeps only its low 9 bits and reads back zero-extended.
- R5: With LAYOUT=0 the counter advances once every two clocks, and the first advance comes two clocks after a counter write. With LAYOUT=1 and LAYOUT=2 it advances on every clock.
- R6: With LAYOUT=0 the timer runs only when control bit 0 and control bit 3 are both set. Its output is high while in the duty part and low otherwise.
- R7: With LAYOUT=1 and LAYOUT=2 the timer runs only when control bit 0 (enable) and bit 1 (continuous) are both set. If bit 3 is set the output is high during the duty part; if it is clear the output is low there. Outside the duty part the output takes the opposite level.
- R8: While the timer is not running, the counter is held at 0. The output drives the idle level: low for LAYOUT=0, and control bit 4 for the other layouts. Everything resets to zero.
- R9: With left alignment (LAYOUT=0, or control bit 5 clear) the output is in the duty part while counter < duty. A tick with counter ≥ period−1, or with period 0, returns the counter to 0. The output is registered and reflects the state one clock earlier.
- R10: With LAYOUT=1 or LAYOUT=2 and control bit 5 set (right alignment), the output is in the duty part while counter ≥ period−duty.
- R11: A duty of 0 keeps the output permanently out of the duty part. A duty ≥ period keeps it permanently in the duty part.
- R12: A counter write loads the written value at that edge and restarts the divide-by-two phase. A value at or beyond period−1 returns to 0 on the next tick.
- R13: Control bit 8 is stored and read back but has no effect on the output or the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one register per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (4) | Byte address; bits [3:2] select the slot |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| pwm_out | output | 1 | Registered PWM output |

## Verification
Every effect of a write is due at the edge that samples the strobe. pwm_out shows the new counter or control state one edge later, and bus_rdata shows a register value at the edge after the read strobe. The divided layout adds one idle clock between counter steps. The bench drives strobes just after a falling edge and samples outputs on the next falling edge. A reference model steps at each rising edge on the same inputs and keeps the same one-edge output lag, so every cycle's pin values can be compared exactly. The directed counter reads are placed a fixed number of falling edges after a counter write, with expected values of W steps (one per clock) or W/2 steps (divided layout).

// File: rtl/pwm_regtimer_pkg.sv
package pwm_regtimer_pkg;

  localparam int CTRL_W  = 9;
  // control bit positions
  localparam int B_EN    = 0;
  localparam int B_CONT  = 1;
  localparam int B_OUTEN = 3;
  localparam int B_POL   = 3;
  localparam int B_IDLE  = 4;
  localparam int B_ALIGN = 5;
  localparam int B_LPWR  = 8;

  typedef enum logic [1:0] {
    RS_CNT  = 2'd0,
    RS_PER  = 2'd1,
    RS_DUTY = 2'd2,
    RS_CTRL = 2'd3
  } reg_role_e;

  typedef struct packed {
    logic run;
    logic act_lvl;
    logic idle_lvl;
    logic right_al;
  } mode_t;

  function automatic reg_role_e slot_role(input int layout, input logic [1:0] slot);
    reg_role_e r;
    case (layout)
      0: begin
        case (slot)
          2'd0:    r = RS_CNT;
          2'd1:    r = RS_DUTY;
          2'd2:    r = RS_PER;
          default: r = RS_CTRL;
        endcase
      end
      1: begin
        case (slot)
          2'd0:    r = RS_CNT;
          2'd1:    r = RS_PER;
          2'd2:    r = RS_DUTY;
          default: r = RS_CTRL;
        endcase
      end
      default: begin
        case (slot)
          2'd0:    r = RS_CTRL;
          2'd1:    r = RS_PER;
          2'd2:    r = RS_DUTY;
          default: r = RS_CNT;
        endcase
      end
    endcase
    return r;
  endfunction

  function automatic int presc_div(input int layout);
    return (layout == 0) ? 2 : 1;
  endfunction

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_regtimer_pkg::*;
#(
  parameter int LAYOUT = 1,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] cnt_q,
  output logic [DATA_W-1:0] per_q,
  output logic [DATA_W-1:0] duty_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              cnt_wr,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int SLOT_LSB = 2;

  reg_role_e        role;
  logic [DATA_W-1:0] rd_mux;

  assign role   = slot_role(LAYOUT, bus_addr[SLOT_LSB+1:SLOT_LSB]);
  assign cnt_wr = bus_wr && (role == RS_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q  <= '0;
      duty_q <= '0;
      ctrl_q <= '0;
    end else if (bus_wr) begin
      case (role)
        RS_PER:  per_q  <= bus_wdata;
        RS_DUTY: duty_q <= bus_wdata;
        RS_CTRL: ctrl_q <= bus_wdata[CTRL_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (role)
      RS_CNT:  rd_mux = cnt_q;
      RS_PER:  rd_mux = per_q;
      RS_DUTY: rd_mux = duty_q;
      default: rd_mux = DATA_W'(ctrl_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/pwm_mode_decode.sv
module pwm_mode_decode
  import pwm_regtimer_pkg::*;
#(
  parameter int LAYOUT = 1
) (
  input  logic [CTRL_W-1:0] ctrl_q,
  output mode_t             mode
);
  generate
    if (LAYOUT == 0) begin : g_plain
      assign mode.run      = ctrl_q[B_EN] & ctrl_q[B_OUTEN];
      assign mode.act_lvl  = 1'b1;
      assign mode.idle_lvl = 1'b0;
      assign mode.right_al = 1'b0;
    end else begin : g_rich
      assign mode.run      = ctrl_q[B_EN] & ctrl_q[B_CONT];
      assign mode.act_lvl  = ctrl_q[B_POL];
      assign mode.idle_lvl = ctrl_q[B_IDLE];
      assign mode.right_al = ctrl_q[B_ALIGN];
    end
  endgenerate

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_regtimer_pkg::*;
#(
  parameter int LAYOUT = 1,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DATA_W-1:0] per_q,
  input  logic              cnt_wr,
  input  logic [DATA_W-1:0] cnt_wdata,
  output logic [DATA_W-1:0] cnt_q,
  output logic              tick
);
  localparam int PRESC = presc_div(LAYOUT);

  logic last;

  generate
    if (PRESC == 2) begin : g_div2
      logic ph_q;
      always_ff @(posedge clk) begin
        if (!rst_n)              ph_q <= 1'b0;
        else if (cnt_wr || !run) ph_q <= 1'b0;
        else                     ph_q <= ~ph_q;
      end
      assign tick = run & ph_q;
    end else begin : g_div1
      assign tick = run;
    end
  endgenerate

  assign last = (per_q == '0) || (cnt_q >= per_q - DATA_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_wr) cnt_q <= cnt_wdata;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= last ? '0 : cnt_q + DATA_W'(1);
  end

endmodule

// File: rtl/pwm_outgen.sv
module pwm_outgen
  import pwm_regtimer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_t             mode,
  input  logic [DATA_W-1:0] cnt_q,
  input  logic [DATA_W-1:0] per_q,
  input  logic [DATA_W-1:0] duty_q,
  output logic              pwm_out
);
  logic in_duty;

  always_comb begin
    if (duty_q == '0)         in_duty = 1'b0;
    else if (duty_q >= per_q) in_duty = 1'b1;
    else if (mode.right_al)   in_duty = (cnt_q >= per_q - duty_q);
    else                      in_duty = (cnt_q < duty_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         pwm_out <= 1'b0;
    else if (!mode.run) pwm_out <= mode.idle_lvl;
    else                pwm_out <= in_duty ? mode.act_lvl : ~mode.act_lvl;
  end

endmodule

// File: rtl/pwm_regtimer.sv
module pwm_regtimer
  import pwm_regtimer_pkg::*;
#(
  parameter int LAYOUT = 1,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);
  logic [DATA_W-1:0] per_q, duty_q, cnt_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              cnt_wr, tick_w, run_w, idle_w;
  mode_t             mode_w;

  pwm_regfile #(.LAYOUT(LAYOUT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_q(cnt_q),
    .per_q(per_q), .duty_q(duty_q), .ctrl_q(ctrl_q),
    .cnt_wr(cnt_wr), .bus_rdata(bus_rdata)
  );

  pwm_mode_decode #(.LAYOUT(LAYOUT)) u_mode (
    .ctrl_q(ctrl_q), .mode(mode_w)
  );

  assign run_w  = mode_w.run;
  assign idle_w = mode_w.idle_lvl;

  pwm_counter #(.LAYOUT(LAYOUT), .DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_w), .per_q(per_q),
    .cnt_wr(cnt_wr), .cnt_wdata(bus_wdata), .cnt_q(cnt_q), .tick(tick_w)
  );

  pwm_outgen #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .mode(mode_w), .cnt_q(cnt_q),
    .per_q(per_q), .duty_q(duty_q), .pwm_out(pwm_out)
  );

endmodule

// File: rtl/pwm_regtimer_chk.sv
module pwm_regtimer_chk #(
  parameter int LAYOUT = 1,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              tick,
  input logic              idle_lvl,
  input logic              cnt_wr,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] per,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              pwm_out
);
  // R8
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> (cnt == '0));

  // R8
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pwm_out == $past(idle_lvl)));

  // R9
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !cnt_wr && ((per == '0) || (cnt >= per - 1))) |=> (cnt == '0));

  // R9
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !cnt_wr && (per != '0) && (cnt < per - 1)) |=> (cnt == $past(cnt) + 1));

  // R5
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !cnt_wr) |=> $stable(cnt));

  // R4
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  generate
    if (LAYOUT == 0) begin : g_div2_chk
      // R5
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

bind pwm_regtimer pwm_regtimer_chk #(.LAYOUT(LAYOUT), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_w), .tick(tick_w), .idle_lvl(idle_w),
  .cnt_wr(cnt_wr), .cnt(cnt_q), .per(per_q), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .pwm_out(pwm_out)
);

// File: tb/test_pwm_regtimer.sv
module test_pwm_regtimer;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        wr_v   [3];
  logic        rd_v   [3];
  logic [3:0]  addr_v [3];
  logic [31:0] wdata;
  logic [31:0] rdata_v[3];
  logic        out_v  [3];

  int    n_chk  = 0;
  int    n_fail = 0;
  logic  chk_on = 1'b0;
  logic  done   = 1'b0;
  string cur_tag = "R8";

  pwm_regtimer #(.LAYOUT(0)) i_pwm_regtimer (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_v[0]), .bus_rd(rd_v[0]), .bus_addr(addr_v[0]),
    .bus_wdata(wdata), .bus_rdata(rdata_v[0]), .pwm_out(out_v[0]));
  pwm_regtimer #(.LAYOUT(1)) i_pwm_regtimer_l1 (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_v[1]), .bus_rd(rd_v[1]), .bus_addr(addr_v[1]),
    .bus_wdata(wdata), .bus_rdata(rdata_v[1]), .pwm_out(out_v[1]));
  pwm_regtimer #(.LAYOUT(2)) i_pwm_regtimer_l2 (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_v[2]), .bus_rd(rd_v[2]), .bus_addr(addr_v[2]),
    .bus_wdata(wdata), .bus_rdata(rdata_v[2]), .pwm_out(out_v[2]));

  // roles: 0 counter, 1 period, 2 duty, 3 control
  function automatic int role_of(int lay, int slot);
    if (lay == 0) return (slot == 0) ? 0 : (slot == 1) ? 2 : (slot == 2) ? 1 : 3;
    if (lay == 1) return slot;
    return (slot == 0) ? 3 : (slot == 3) ? 0 : slot;
  endfunction

  function automatic int slot_of(int lay, int role);
    for (int s = 0; s < 4; s++) if (role_of(lay, s) == role) return s;
    return 0;
  endfunction

  // reference model
  logic [31:0] m_cnt[3], m_per[3], m_duty[3], m_rd[3];
  logic [8:0]  m_ctrl[3];
  logic        m_ph[3], m_out[3];

  function automatic logic m_run(int lay);
    if (lay == 0) return m_ctrl[0][0] & m_ctrl[0][3];
    return m_ctrl[lay][0] & m_ctrl[lay][1];
  endfunction

  function automatic logic m_level(int lay);
    logic act, idle, right, on;
    act   = (lay == 0) ? 1'b1 : m_ctrl[lay][3];
    idle  = (lay == 0) ? 1'b0 : m_ctrl[lay][4];
    right = (lay == 0) ? 1'b0 : m_ctrl[lay][5];
    if (!m_run(lay)) return idle;
    if (m_duty[lay] == 0)                on = 1'b0;
    else if (m_duty[lay] >= m_per[lay])  on = 1'b1;
    else if (right)                      on = (m_cnt[lay] >= m_per[lay] - m_duty[lay]);
    else                                 on = (m_cnt[lay] < m_duty[lay]);
    return on ? act : ~act;
  endfunction

  function automatic logic [31:0] m_value(int lay, int role);
    case (role)
      0: return m_cnt[lay];
      1: return m_per[lay];
      2: return m_duty[lay];
      default: return {23'd0, m_ctrl[lay]};
    endcase
  endfunction

  always @(posedge clk) begin
    for (int lay = 0; lay < 3; lay++) begin
      logic        run_o, tk, np, nout;
      logic [31:0] nc;
      int          r;
      if (!rst_n) begin
        m_cnt[lay] = 0; m_per[lay] = 0; m_duty[lay] = 0; m_rd[lay] = 0;
        m_ctrl[lay] = 0; m_ph[lay] = 0; m_out[lay] = 0;
      end else begin
        run_o = m_run(lay);
        tk    = run_o && ((lay != 0) || m_ph[lay]);
        nout  = m_level(lay);
        r     = role_of(lay, int'(addr_v[lay][3:2]));
        if (rd_v[lay]) m_rd[lay] = m_value(lay, r);
        if (wr_v[lay] && r == 0) begin
          nc = wdata; np = 1'b0;
        end else if (!run_o) begin
          nc = 0; np = 1'b0;
        end else begin
          np = (lay == 0) ? ~m_ph[lay] : 1'b0;
          if (tk) nc = ((m_per[lay] == 0) || (m_cnt[lay] >= m_per[lay] - 1)) ? 0 : m_cnt[lay] + 1;
          else    nc = m_cnt[lay];
        end
        if (wr_v[lay] && r == 1) m_per[lay]  = wdata;
        if (wr_v[lay] && r == 2) m_duty[lay] = wdata;
        if (wr_v[lay] && r == 3) m_ctrl[lay] = wdata[8:0];
        m_cnt[lay] = nc; m_ph[lay] = np; m_out[lay] = nout;
      end
    end
  end

  // per-cycle output comparison
  always @(negedge clk) begin
    if (chk_on) begin
      for (int lay = 0; lay < 3; lay++) begin
        n_chk++;
        if (out_v[lay] !== m_out[lay]) begin
          n_fail++;
          $display("FAIL %s layout %0d pwm_out actual %b expected %b", cur_tag, lay, out_v[lay], m_out[lay]);
        end
      end
    end
  end

  task automatic wr_all(int role, logic [31:0] d);
    for (int lay = 0; lay < 3; lay++) begin
      int s;
      logic [1:0] lo;
      s  = slot_of(lay, role);
      lo = 2'($urandom % 4);
      addr_v[lay] = {s[1:0], lo};
      wr_v[lay]   = 1'b1;
    end
    wdata = d;
    @(negedge clk);
    for (int lay = 0; lay < 3; lay++) wr_v[lay] = 1'b0;
  endtask

  task automatic rd_all(int role, logic use_exp, logic [31:0] e0, logic [31:0] e1, logic [31:0] e2, string tag);
    logic [31:0] ev[3];
    ev[0] = e0; ev[1] = e1; ev[2] = e2;
    for (int lay = 0; lay < 3; lay++) begin
      int s;
      s = slot_of(lay, role);
      addr_v[lay] = {s[1:0], 2'b00};
      rd_v[lay]   = 1'b1;
    end
    @(negedge clk);
    for (int lay = 0; lay < 3; lay++) begin
      logic [31:0] e;
      rd_v[lay] = 1'b0;
      e = use_exp ? ev[lay] : m_rd[lay];
      n_chk++;
      if (rdata_v[lay] !== e) begin
        n_fail++;
        $display("FAIL %s layout %0d read role %0d actual %h expected %h", tag, lay, role, rdata_v[lay], e);
      end
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired (%s)", cur_tag);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    wdata = '0;
    for (int lay = 0; lay < 3; lay++) begin
      wr_v[lay] = 1'b0; rd_v[lay] = 1'b0; addr_v[lay] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n  = 1'b1;
    chk_on = 1'b1;

    // R8 reset state
    cur_tag = "R8";
    for (int role = 0; role < 4; role++) rd_all(role, 1'b1, 0, 0, 0, "R8");

    // R1 R2 R3 slot map, R4 control truncation
    cur_tag = "R1";
    wr_all(1, 32'h22);
    wr_all(2, 32'h11);
    wr_all(3, 32'hFFFF_FFF0);
    wr_all(0, 32'd5);
    step(2);
    rd_all(1, 1'b1, 32'h22, 32'h22, 32'h22, "R1 R2 R3 period");
    rd_all(2, 1'b1, 32'h11, 32'h11, 32'h11, "R1 R2 R3 duty");
    rd_all(3, 1'b1, 32'h1F0, 32'h1F0, 32'h1F0, "R4 control");
    rd_all(0, 1'b1, 0, 0, 0, "R8 counter held");

    // R5 tick rate
    cur_tag = "R5";
    wr_all(1, 32'd100);
    wr_all(2, 32'd50);
    wr_all(3, 32'h00B);
    wr_all(0, 32'd0);
    step(20);
    rd_all(0, 1'b1, 32'd10, 32'd20, 32'd20, "R5");

    // R6 both bits needed on layout 0
    cur_tag = "R6";
    wr_all(1, 32'd6);
    wr_all(2, 32'd2);
    wr_all(3, 32'h001);
    step(20);
    rd_all(0, 1'b1, 0, 0, 0, "R6");
    wr_all(3, 32'h008);
    step(10);
    wr_all(3, 32'h009);
    step(30);

    // R7 polarity on rich layouts
    cur_tag = "R7";
    wr_all(1, 32'd7);
    wr_all(2, 32'd3);
    wr_all(3, 32'h003);
    step(30);
    wr_all(3, 32'h00B);
    step(30);

    // R8 idle level
    cur_tag = "R8";
    wr_all(3, 32'h010);
    step(10);
    rd_all(0, 1'b1, 0, 0, 0, "R8");
    wr_all(3, 32'h000);
    step(5);

    // R9 left aligned, wrap, period 0
    cur_tag = "R9";
    wr_all(3, 32'h00B);
    wr_all(1, 32'd4);
    wr_all(2, 32'd1);
    wr_all(0, 32'd0);
    step(24);
    wr_all(1, 32'd0);
    wr_all(2, 32'd0);
    step(10);
    rd_all(0, 1'b1, 0, 0, 0, "R9 period 0");
    wr_all(1, 32'd1);
    step(10);

    // R10 right aligned
    cur_tag = "R10";
    wr_all(1, 32'd8);
    wr_all(2, 32'd3);
    wr_all(3, 32'h02B);
    wr_all(0, 32'd0);
    step(30);

    // R11 duty extremes
    cur_tag = "R11";
    wr_all(3, 32'h00B);
    wr_all(1, 32'd5);
    wr_all(2, 32'd5);
    step(15);
    wr_all(2, 32'd9);
    step(15);
    wr_all(2, 32'd0);
    step(15);
    wr_all(3, 32'h02B);
    step(15);
    wr_all(2, 32'd8);
    step(15);

    // R12 counter load
    cur_tag = "R12";
    wr_all(3, 32'h00B);
    wr_all(1, 32'd10);
    wr_all(2, 32'd4);
    wr_all(0, 32'd3);
    rd_all(0, 1'b1, 32'd3, 32'd3, 32'd3, "R12");
    wr_all(0, 32'd50);
    step(12);
    rd_all(0, 1'b0, 0, 0, 0, "R12");

    // R13 low-power bit stored, no effect
    cur_tag = "R13";
    wr_all(3, 32'h10B);
    step(30);
    rd_all(3, 1'b1, 32'h10B, 32'h10B, 32'h10B, "R13");

    // constrained random mix
    cur_tag = "R9";
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom % 6);
      case (op)
        0: wr_all(1, 32'($urandom % 16));
        1: wr_all(2, 32'($urandom % 18));
        2: wr_all(3, (32'($urandom) & 32'h1FF) | (($urandom % 2) ? 32'h00B : 32'h0));
        3: wr_all(0, 32'($urandom % 21));
        4: rd_all(int'($urandom % 4), 1'b0, 0, 0, 0, "R4");
        default: ;
      endcase
      step(1 + int'($urandom % 12));
    end

    done   = 1'b1;
    chk_on = 1'b0;
    summary();
    $finish;
  end

endmodule